// File: doc/BRIEF.md
# Selective Ethernet Reset Sequencer

This block owns the reset and readiness controls of a small Ethernet MAC/PHY subsystem. Software writes a control register holding two independent reset bits, one for the transmit datapath and one for the receive datapath. Each bit holds its datapath in reset for as long as it stays set. The buffer-management and host-interface resets follow only the global device reset. A module enable bit starts a PHY start-up timer, and the PHY-ready flag sets in a status register when that timer expires.

Accesses to the PHY register window are refused while the PHY is not ready. When either selective reset bit is cleared, a hold-off window opens. For that window every register write is ignored and a lockout flag is shown. The start-up and hold-off lengths are parameters counted in clock cycles. The register bus is synchronous, and read data appears one cycle after the read strobe.

Top module: `eth_rst_seq`

## Requirements
- R1: Control register (address 0) bit 7 is the transmit reset bit. `tx_rst_o` is high while this bit is 1 or while the global reset is high, and the bit takes a written value on the clock edge of an accepted write.
- R2: Control register bit 6 is the receive reset bit. `rx_rst_o` is high while this bit is 1 or while the global reset is high, and it is independent of bit 7.
- R3: `buf_rst_o` and `host_rst_o` follow the global reset only. The selective reset bits never raise them.
- R4: The reset bits never clear themselves. They change only through a control write or a global reset.
- R5: On the edge where either reset bit goes from 1 to 0, `wr_lock_o` (status bit 1) rises and stays high for exactly HOLD_CYCLES cycles. Every write made while it is high is ignored, including writes to the PHY window.
- R6: A control write made during the lockout that has bit 7 or bit 6 at 0 reloads the hold-off count, so the lockout then lasts HOLD_CYCLES more cycles.
- R7: Control bit 5 is the module enable. `phy_ready_o` (status bit 0) rises exactly START_CYCLES cycles after the edge on which the enable was written to 1.
- R8: Clearing the enable drops `phy_ready_o` on the following edge and restarts the start-up count from zero.
- R9: A read or an accepted write at address 2 (the PHY window) pulses `phy_grant_o` in the same cycle when the PHY is ready. When the PHY is not ready it pulses `phy_reject_o` instead.
- R10: While the global reset is high, all control bits, PHY-ready and the lockout return to 0, and the start-up timer restarts.
- R11: `rdata_o` carries the addressed register on the cycle after `rd_en_i` and reads 0 otherwise. The control register reads as {tx, rx, en, 00000} and the status register reads as {000000, lock, ready}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Global synchronous reset, active high |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read |
| tx_rst_o | output | 1 | Transmit datapath reset |
| rx_rst_o | output | 1 | Receive datapath reset |
| buf_rst_o | output | 1 | Buffer-management reset |
| host_rst_o | output | 1 | Host-interface reset |
| phy_ready_o | output | 1 | PHY start-up complete |
| wr_lock_o | output | 1 | Register write lockout active |
| phy_grant_o | output | 1 | PHY window access allowed |
| phy_reject_o | output | 1 | PHY window access refused |

## Verification
A table of control writes steps the two reset bits through the cases set-only, both-set, single fall, a repeated 0 and the other bit's fall. This separates the transmit and receive outputs and shows whether a lockout follows only real 1-to-0 transitions. Directed sequences measure the lockout length with and without a restarting write. They also measure the start-up delay before and after the enable is toggled. PHY window accesses are made before ready, after ready and during a lockout, which shows that grant, reject and ignore are distinct outcomes. A global reset in the middle of operation then shows that the full start-up delay is needed again.

// File: rtl/eth_rst_pkg.sv
package eth_rst_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_PHY  = 2'd2;

  localparam int B_TXR = 7;
  localparam int B_RXR = 6;
  localparam int B_EN  = 5;
  localparam int B_RDY = 0;
  localparam int B_LCK = 1;

  // width of a counter that runs from 0 to n-1
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // a selective reset bit being released
  function automatic logic released(input logic old_v, input logic new_v);
    return old_v & ~new_v;
  endfunction

  // a control write in the lockout that names a reset bit as 0
  function automatic logic reload_hold(input logic lock, input logic wr_ctrl,
                                       input logic tx_v, input logic rx_v);
    return lock & wr_ctrl & (~tx_v | ~rx_v);
  endfunction
endpackage

// File: rtl/eth_rst_regs.sv
module eth_rst_regs
  import eth_rst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic wr_ctrl_i,
  input  logic tx_d_i,
  input  logic rx_d_i,
  input  logic en_d_i,
  output logic tx_q_o,
  output logic rx_q_o,
  output logic en_q_o,
  output logic tx_fell_o,
  output logic rx_fell_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tx_q_o <= 1'b0;
      rx_q_o <= 1'b0;
      en_q_o <= 1'b0;
    end else if (wr_ctrl_i) begin
      tx_q_o <= tx_d_i;
      rx_q_o <= rx_d_i;
      en_q_o <= en_d_i;
    end
  end

  assign tx_fell_o = wr_ctrl_i & released(tx_q_o, tx_d_i);
  assign rx_fell_o = wr_ctrl_i & released(rx_q_o, rx_d_i);
endmodule

// File: rtl/eth_rst_startup.sv
module eth_rst_startup
  import eth_rst_pkg::*;
#(
  parameter int START_CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic ready_o
);
  localparam int CW = cnt_w(START_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(START_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      if (cnt_q == LAST) ready_o <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/eth_rst_holdoff.sv
module eth_rst_holdoff
  import eth_rst_pkg::*;
#(
  parameter int HOLD_CYCLES = 200000000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  output logic lock_o
);
  localparam int CW = cnt_w(HOLD_CYCLES);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_q <= '0;
      lock_o <= 1'b0;
    end else if (load_i) begin
      left_q <= FULL;
      lock_o <= 1'b1;
    end else if (lock_o) begin
      if (left_q == '0) lock_o <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/eth_rst_seq.sv
module eth_rst_seq
  import eth_rst_pkg::*;
#(
  parameter int START_CYCLES = 125000,
  parameter int HOLD_CYCLES  = 200000000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_rst_o,
  output logic              rx_rst_o,
  output logic              buf_rst_o,
  output logic              host_rst_o,
  output logic              phy_ready_o,
  output logic              wr_lock_o,
  output logic              phy_grant_o,
  output logic              phy_reject_o
);
  // named internal events
  logic wr_ok, wr_ctrl, hold_reload, hold_load, phy_req;
  logic tx_q, rx_q, en_q, tx_fell, rx_fell;
  logic [DATA_W-1:0] rd_mux;
  wire  unused_wdata = ^wdata_i[B_EN-1:0];

  assign wr_ok       = wr_en_i & ~wr_lock_o;
  assign wr_ctrl     = wr_ok & (addr_i == A_CTRL);
  assign hold_reload = reload_hold(wr_lock_o, wr_en_i & (addr_i == A_CTRL),
                                   wdata_i[B_TXR], wdata_i[B_RXR]);
  assign hold_load   = tx_fell | rx_fell | hold_reload;

  eth_rst_regs u_regs (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_ctrl_i(wr_ctrl),
    .tx_d_i   (wdata_i[B_TXR]),
    .rx_d_i   (wdata_i[B_RXR]),
    .en_d_i   (wdata_i[B_EN]),
    .tx_q_o   (tx_q),
    .rx_q_o   (rx_q),
    .en_q_o   (en_q),
    .tx_fell_o(tx_fell),
    .rx_fell_o(rx_fell)
  );

  eth_rst_startup #(.START_CYCLES(START_CYCLES)) u_start (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_q),
    .ready_o(phy_ready_o)
  );

  eth_rst_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(hold_load),
    .lock_o(wr_lock_o)
  );

  assign tx_rst_o   = rst_i | tx_q;
  assign rx_rst_o   = rst_i | rx_q;
  assign buf_rst_o  = rst_i;
  assign host_rst_o = rst_i;

  assign phy_req      = (addr_i == A_PHY) & (rd_en_i | wr_ok);
  assign phy_grant_o  = phy_req & phy_ready_o;
  assign phy_reject_o = phy_req & ~phy_ready_o;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CTRL: begin
        rd_mux[B_TXR] = tx_q;
        rd_mux[B_RXR] = rx_q;
        rd_mux[B_EN]  = en_q;
      end
      A_STAT: begin
        rd_mux[B_RDY] = phy_ready_o;
        rd_mux[B_LCK] = wr_lock_o;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
    else              rdata_o <= '0;
  end
endmodule

module eth_rst_seq_chk
  import eth_rst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              tx_rst_o,
  input logic              rx_rst_o,
  input logic              buf_rst_o,
  input logic              host_rst_o,
  input logic              phy_ready_o,
  input logic              wr_lock_o,
  input logic              phy_grant_o,
  input logic              phy_reject_o,
  input logic              en_q
);
  // R1 R2
  ctrl_write_takes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i && !wr_lock_o && addr_i == A_CTRL |=>
      tx_rst_o == $past(wdata_i[B_TXR]) && rx_rst_o == $past(wdata_i[B_RXR]));

  // R3
  side_resets_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_rst_o || rx_rst_o) |-> !buf_rst_o && !host_rst_o);

  // R4
  bits_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i && !(wr_en_i && addr_i == A_CTRL) |=> $stable(tx_rst_o) && $stable(rx_rst_o));

  // R5
  release_locks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && ($fell(tx_rst_o) || $fell(rx_rst_o)) |-> wr_lock_o);

  // R5
  locked_write_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i && wr_lock_o && wr_en_i |=> $stable(tx_rst_o) && $stable(rx_rst_o));

  // R7
  ready_needs_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(phy_ready_o) |-> en_q);

  // R8
  disable_drops_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_q |=> !phy_ready_o);

  // R9
  grant_when_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    phy_grant_o |-> phy_ready_o && !phy_reject_o);

  // R9
  reject_when_not_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    phy_reject_o |-> !phy_ready_o);
endmodule

bind eth_rst_seq eth_rst_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .tx_rst_o    (tx_rst_o),
  .rx_rst_o    (rx_rst_o),
  .buf_rst_o   (buf_rst_o),
  .host_rst_o  (host_rst_o),
  .phy_ready_o (phy_ready_o),
  .wr_lock_o   (wr_lock_o),
  .phy_grant_o (phy_grant_o),
  .phy_reject_o(phy_reject_o),
  .en_q        (en_q)
);

// File: tb/test_eth_rst_seq.sv
module test_eth_rst_seq;
  localparam int START = 10;
  localparam int HOLD  = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic tx_rst, rx_rst, buf_rst, host_rst, ready, lock, grant, reject;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  eth_rst_seq #(.START_CYCLES(START), .HOLD_CYCLES(HOLD)) i_eth_rst_seq (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tx_rst_o(tx_rst), .rx_rst_o(rx_rst),
    .buf_rst_o(buf_rst), .host_rst_o(host_rst), .phy_ready_o(ready),
    .wr_lock_o(lock), .phy_grant_o(grant), .phy_reject_o(reject)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // number of sampled cycles while lock stays high
  task automatic lock_len(output int n);
    n = 0;
    while (lock && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic wait_unlock();
    int guard = 0;
    while (lock && guard < 100) begin guard++; @(negedge clk); end
  endtask

  // {wdata, exp_tx, exp_rx, exp_lock}
  localparam logic [10:0] VEC [8] = '{
    {8'h80, 1'b1, 1'b0, 1'b0},
    {8'hC0, 1'b1, 1'b1, 1'b0},
    {8'h40, 1'b0, 1'b1, 1'b1},
    {8'h40, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b1},
    {8'h80, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    // R3 R10: resets during global reset
    chk(buf_rst && host_rst && tx_rst && rx_rst, "R3/R10 in reset", {buf_rst, host_rst, tx_rst, rx_rst}, 4'hF);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_rst && !rx_rst && !buf_rst && !host_rst && !ready && !lock, "R10 after reset",
        {tx_rst, rx_rst, buf_rst, host_rst, ready, lock}, 0);
    rd_reg(2'd1, d);
    chk(d == 8'h00, "R11 status after reset", d, 8'h00);
    @(negedge clk);
    chk(rdata == 8'h00, "R11 idle read zero", rdata, 0);

    // table: R1 R2 R3 R4 R5
    foreach (VEC[i]) begin
      wait_unlock();
      wr_reg(2'd0, VEC[i][10:3]);
      chk(tx_rst == VEC[i][2], "R1 tx reset", tx_rst, VEC[i][2]);
      chk(rx_rst == VEC[i][1], "R2 rx reset", rx_rst, VEC[i][1]);
      chk(!buf_rst && !host_rst, "R3 side resets", {buf_rst, host_rst}, 0);
      chk(lock == VEC[i][0], "R5 lock on release", lock, VEC[i][0]);
    end
    wait_unlock();

    // R4: no self clearing
    wr_reg(2'd0, 8'hC0);
    repeat (20) @(negedge clk);
    chk(tx_rst && rx_rst, "R4 bits persist", {tx_rst, rx_rst}, 2'b11);

    // R5: lockout length and ignored write
    wr_reg(2'd0, 8'h00);
    lock_len(n);
    chk(n == HOLD, "R5 lockout length", n, HOLD);
    wr_reg(2'd0, 8'h80);
    wr_reg(2'd0, 8'h00);
    @(negedge clk); @(negedge clk);
    wr_reg(2'd0, 8'hC0);   // bit 7 clear? no: bit6 set, bit7 set -> no reload, ignored
    chk(!tx_rst && !rx_rst, "R5 locked write ignored", {tx_rst, rx_rst}, 0);
    wait_unlock();

    // R6: reload by write with a 0 reset bit
    wr_reg(2'd0, 8'h80);
    wr_reg(2'd0, 8'h00);
    @(negedge clk); @(negedge clk);
    wr_reg(2'd0, 8'h80);
    chk(!tx_rst, "R6 reload write ignored", tx_rst, 0);
    lock_len(n);
    chk(n == HOLD, "R6 lockout restarted", n, HOLD);

    // R9: PHY window before ready
    @(negedge clk); addr = 2'd2; rd = 1'b1; #1;
    chk(reject && !grant, "R9 reject before ready", {grant, reject}, 2'b01);
    @(negedge clk); rd = 1'b0;

    // R7: start-up delay
    wr_reg(2'd0, 8'h20);
    n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk(n == START, "R7 start-up delay", n, START);
    rd_reg(2'd1, d);
    chk(d == 8'h01, "R11 status ready", d, 8'h01);
    rd_reg(2'd0, d);
    chk(d == 8'h20, "R11 control readback", d, 8'h20);

    // R9: grant once ready
    @(negedge clk); addr = 2'd2; wr = 1'b1; #1;
    chk(grant && !reject, "R9 grant when ready", {grant, reject}, 2'b10);
    @(negedge clk); wr = 1'b0;

    // R5 R9: PHY write during lockout ignored
    wr_reg(2'd0, 8'hA0);
    wr_reg(2'd0, 8'h20);
    @(negedge clk); addr = 2'd2; wr = 1'b1; #1;
    chk(!grant && !reject, "R5 PHY write in lockout", {grant, reject}, 0);
    @(negedge clk); wr = 1'b0;
    wait_unlock();

    // R8: disable clears ready next edge, restart count
    wr_reg(2'd0, 8'h00);
    chk(ready, "R8 ready one more cycle", ready, 1);
    @(negedge clk);
    chk(!ready, "R8 ready cleared", ready, 0);
    wr_reg(2'd0, 8'h20);
    n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk(n == START, "R8 timer restarted", n, START);

    // R10: global reset mid operation
    wr_reg(2'd0, 8'hE0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(buf_rst && host_rst, "R10 side resets in reset", {buf_rst, host_rst}, 2'b11);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_rst && !rx_rst && !ready && !lock, "R10 cleared", {tx_rst, rx_rst, ready, lock}, 0);
    wr_reg(2'd0, 8'h20);
    n = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk(n == START, "R10 timer restart", n, START);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule